// File: doc/BRIEF.md
# Core Memory Read-Restore Controller

This block sequences every access to a word-organised magnetic core store. The store is a stack of bit planes that share one set of X and Y select lines. Each plane holds one bit of the word and has its own sense line and inhibit line. Reading switches the selected cores toward zero, so a read always destroys the stored word. For that reason every access, read or write, runs as a full clear-then-write cycle. First comes a read drive, then a sense sample. After a recovery gap, a write drive sets the selected cores to one, except in the planes whose inhibit is raised.

The requester offers an operation with a valid/ready handshake. A read returns the sensed word with a single-cycle valid pulse, and the controller then restores that same word on its own. A write still runs the destructive read phase, throws the sensed word away and stores the new data. The sense line of a plane may share its wire with that plane's inhibit line, so the controller keeps the sampling window and the inhibit drive apart in time.

Top module: `core_store_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `x_drive`, `y_drive`, `inhibit_en`, `sense_en` and `rd_valid` are all 0.
- R2: An accepted request keeps `req_ready` low for exactly READ_CYC+SENSE_CYC+RECOV_CYC+WRITE_CYC+DONE_CYC cycles (11 with the defaults). The phases run in the order read drive, sense, recover, write drive, done.
- R3: `x_drive` and `y_drive` are always asserted together, never one without the other. During a drive, `x_addr` is the low ADDR_W/2 bits of the request address and `y_addr` is the remaining high bits, and both hold steady for the whole operation.
- R4: `drive_pol` is 0 (toward zero) in each of the READ_CYC read-drive cycles and 1 (toward one) in each of the WRITE_CYC write-drive cycles.
- R5: During the write drive, `inhibit_en[i]` equals the inverse of bit i of the word being stored. Outside the write drive, `inhibit_en` is all zero.
- R6: `sense_in` is captured only in the single cycle in which `sense_en` is 1, which is cycle STROBE_POS of the sense phase. Pulses in any other cycle have no effect on `rd_data`.
- R7: `inhibit_en` is never non-zero in a cycle where `sense_en` is 1.
- R8: For a read (`req_write`=0), `rd_valid` pulses for exactly one cycle, in the first cycle after the sense phase (cycle READ_CYC+SENSE_CYC+1 after acceptance). `rd_data` then equals the stored word, and the same word is written back.
- R9: For a write (`req_write`=1), the read phase still runs, `rd_valid` stays 0, and the addressed word afterwards holds `req_wdata`.
- R10: Repeated reads of a word, and a reset of the controller between accesses, leave the stored contents unchanged.
- R11: `req_valid` is ignored while `req_ready` is 0. A request offered during a busy operation changes neither that operation nor any stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word to store on a write |
| req_ready | output | 1 | Idle, able to accept a request |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds the read word |
| rd_data | output | DATA_W | Last sensed word |
| x_addr | output | ADDR_W/2 | X line select (low address bits) |
| y_addr | output | ADDR_W-ADDR_W/2 | Y line select (high address bits) |
| x_drive | output | 1 | X half-select current strobe |
| y_drive | output | 1 | Y half-select current strobe |
| drive_pol | output | 1 | 0 = drive toward zero (read), 1 = toward one (write) |
| inhibit_en | output | DATA_W | Per-plane inhibit enable |
| sense_en | output | 1 | Sense sampling window (shared line in sense mode) |
| sense_in | input | DATA_W | Per-plane sense pulses |

## Verification
The assertions assume that `sense_in` carries flip pulses only in the cycles after a read drive. They also assume the requester offers new work only when it is idle, except for the stray requests the bench injects on purpose. They take nothing for granted about `sense_in` outside the strobe cycle. The bench's core-plane model changes a core only when X and Y are driven together. It emits each plane's flip as a pulse that spans the whole sense phase, and it ORs random noise into `sense_in` in every cycle where `sense_en` is low. This stresses the strobe window without ever breaking the model's physics.

// File: rtl/core_ctrl_pkg.sv
// Package: shared phase encoding for the core store controller.
// Assumes: phases are visited strictly in declaration order after PH_IDLE.
package core_ctrl_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_READ  = 3'd1,
        PH_SENSE = 3'd2,
        PH_RECOV = 3'd3,
        PH_WRITE = 3'd4,
        PH_DONE  = 3'd5
    } phase_t;

    // Larger of two lengths, used to size the phase counter.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/core_phase_seq.sv
// Phase sequencer: steps IDLE -> READ -> SENSE -> RECOV -> WRITE -> DONE -> IDLE.
// Each non-idle phase lasts its own parameterised number of clocks.
// It also flags the single strobe cycle inside the sense phase.
// Assumes: every length is >= 1 and STROBE_POS < SENSE_CYC.
module core_phase_seq
    import core_ctrl_pkg::*;
#(
    parameter int READ_CYC   = 3,
    parameter int SENSE_CYC  = 2,
    parameter int STROBE_POS = 0,
    parameter int RECOV_CYC  = 2,
    parameter int WRITE_CYC  = 3,
    parameter int DONE_CYC   = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_t phase_o,
    output logic   last_o,
    output logic   strobe_o
);
    localparam int MAX_LEN = max2(max2(READ_CYC, SENSE_CYC),
                                  max2(max2(RECOV_CYC, WRITE_CYC), DONE_CYC));
    localparam int CNT_W   = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_m1;

    // Final count value of the current phase.
    always_comb begin
        case (phase_q)
            PH_READ:  len_m1 = CNT_W'(READ_CYC - 1);
            PH_SENSE: len_m1 = CNT_W'(SENSE_CYC - 1);
            PH_RECOV: len_m1 = CNT_W'(RECOV_CYC - 1);
            PH_WRITE: len_m1 = CNT_W'(WRITE_CYC - 1);
            PH_DONE:  len_m1 = CNT_W'(DONE_CYC - 1);
            default:  len_m1 = '0;
        endcase
    end

    assign last_o   = (phase_q != PH_IDLE) && (cnt_q == len_m1);
    assign strobe_o = (phase_q == PH_SENSE) && (cnt_q == CNT_W'(STROBE_POS));
    assign phase_o  = phase_q;

    // Advance the phase and its cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (phase_q == PH_IDLE) begin
            cnt_q <= '0;
            if (start) phase_q <= PH_READ;
        end else if (last_o) begin
            cnt_q <= '0;
            case (phase_q)
                PH_READ:  phase_q <= PH_SENSE;
                PH_SENSE: phase_q <= PH_RECOV;
                PH_RECOV: phase_q <= PH_WRITE;
                PH_WRITE: phase_q <= PH_DONE;
                default:  phase_q <= PH_IDLE;
            endcase
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    start_enters_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && start) |=> (phase_q == PH_READ && cnt_q == '0));
    // R2
    write_after_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_q == PH_WRITE) |-> $past(phase_q) == PH_RECOV);
    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o || SENSE_CYC == 1);
endmodule

// File: rtl/core_sense_latch.sv
// Sense latch: captures the per-plane sense pulses in the strobe cycle only
// and holds that word until the next strobe.
// Assumes: strobe is high for at most one cycle per access.
module core_sense_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [DATA_W-1:0] sense_in,
    output logic [DATA_W-1:0] word_o
);
    logic [DATA_W-1:0] word_q;

    // Sample the sense lines inside the strobe window.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (strobe) word_q <= sense_in;
    end

    assign word_o = word_q;

    // R6
    hold_outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(word_q));
endmodule

// File: rtl/core_wb_select.sv
// Write-back selection: records the operation type and new data at acceptance.
// It picks the word to restore (sensed word for a read, new data for a write)
// and produces the per-plane inhibit vector for the write drive.
// Assumes: accept is a single-cycle pulse at request acceptance.
module core_wb_select #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] sensed_word,
    input  logic              write_phase,
    output logic              is_write_o,
    output logic [DATA_W-1:0] inhibit_o
);
    logic              is_write_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] wb_word;

    // Capture the operation at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_write_q <= 1'b0;
            wdata_q    <= '0;
        end else if (accept) begin
            is_write_q <= req_write;
            wdata_q    <= req_wdata;
        end
    end

    // Pick the restore word and invert it into inhibit enables.
    always_comb begin
        wb_word   = is_write_q ? wdata_q : sensed_word;
        inhibit_o = write_phase ? ~wb_word : '0;
    end

    assign is_write_o = is_write_q;

    // R9
    op_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(is_write_q) && $stable(wdata_q));
endmodule

// File: rtl/core_store_ctrl.sv
// Core store controller top: accepts read/write requests and runs one
// destructive-read plus write-back cycle per request over stacked bit planes.
// Assumes: sense_in carries per-plane flip pulses after a read drive; the
// requester may offer requests at any time, but they are taken only in idle.
module core_store_ctrl
    import core_ctrl_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 6,
    parameter int READ_CYC   = 3,
    parameter int SENSE_CYC  = 2,
    parameter int STROBE_POS = 0,
    parameter int RECOV_CYC  = 2,
    parameter int WRITE_CYC  = 3,
    parameter int DONE_CYC   = 1,
    localparam int XW = ADDR_W / 2,
    localparam int YW = ADDR_W - XW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [XW-1:0]     x_addr,
    output logic [YW-1:0]     y_addr,
    output logic              x_drive,
    output logic              y_drive,
    output logic              drive_pol,
    output logic [DATA_W-1:0] inhibit_en,
    output logic              sense_en,
    input  logic [DATA_W-1:0] sense_in
);
    phase_t            phase;
    logic              last;
    logic              strobe;
    logic              accept;
    logic              is_write;
    logic              rd_valid_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] sensed;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_ready && req_valid;

    core_phase_seq #(
        .READ_CYC  (READ_CYC),
        .SENSE_CYC (SENSE_CYC),
        .STROBE_POS(STROBE_POS),
        .RECOV_CYC (RECOV_CYC),
        .WRITE_CYC (WRITE_CYC),
        .DONE_CYC  (DONE_CYC)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .phase_o (phase),
        .last_o  (last),
        .strobe_o(strobe)
    );

    core_sense_latch #(.DATA_W(DATA_W)) latch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (strobe),
        .sense_in(sense_in),
        .word_o  (sensed)
    );

    core_wb_select #(.DATA_W(DATA_W)) wb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .sensed_word(sensed),
        .write_phase(phase == PH_WRITE),
        .is_write_o (is_write),
        .inhibit_o  (inhibit_en)
    );

    // Hold the address of the operation in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= req_addr;
    end

    // Flag read data in the first cycle after the sense phase.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid_q <= 1'b0;
        else        rd_valid_q <= (phase == PH_SENSE) && last && !is_write;
    end

    // Drive strobes and polarity come straight from the phase.
    always_comb begin
        x_drive   = (phase == PH_READ) || (phase == PH_WRITE);
        y_drive   = x_drive;
        drive_pol = (phase == PH_WRITE);
        sense_en  = strobe;
    end

    assign x_addr   = addr_q[XW-1:0];
    assign y_addr   = addr_q[ADDR_W-1:XW];
    assign rd_valid = rd_valid_q;
    assign rd_data  = sensed;

    // R7
    no_inhibit_in_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sense_en |-> inhibit_en == '0);
    // R5
    inhibit_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(x_drive && drive_pol) |-> inhibit_en == '0);
    // R3
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> ($stable(x_addr) && $stable(y_addr)));
    // R1
    idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !x_drive && !y_drive && !sense_en);
    // R8
    rd_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R9
    no_rd_valid_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !is_write);
endmodule

// File: tb/core_store_ctrl_tb_top.sv
`timescale 1ns/1ps
module core_store_ctrl_tb_top;
    localparam int DW = 8, AW = 6, RC = 3, SC = 2, RV = 2, WC = 3, DC = 1;
    localparam int TOTAL = RC + SC + RV + WC + DC;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rd_valid, x_drive, y_drive, drive_pol, sense_en;
    logic [DW-1:0] rd_data, inhibit_en, sense_in;
    logic [AW/2-1:0]    x_addr;
    logic [AW-AW/2-1:0] y_addr;

    always #2.5 clk = ~clk;

    core_store_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .x_addr(x_addr), .y_addr(y_addr),
        .x_drive(x_drive), .y_drive(y_drive), .drive_pol(drive_pol),
        .inhibit_en(inhibit_en), .sense_en(sense_en), .sense_in(sense_in)
    );

    // ---- behavioural core-plane model ----
    logic [DW-1:0] cores [NW];
    logic [DW-1:0] flip = '0;
    logic [DW-1:0] noise = '0;
    int            hold = 0;
    logic          rd_prev = 1'b0;
    wire [AW-1:0]  m_addr = {y_addr, x_addr};
    wire           coinc = x_drive && y_drive;
    wire [DW-1:0]  model_sense = (hold != 0 && !coinc) ? flip : '0;
    assign sense_in = model_sense | (sense_en ? '0 : noise);

    always @(posedge clk) begin
        if (coinc && !drive_pol) begin
            if (!rd_prev) flip <= cores[m_addr];
            cores[m_addr] <= '0;
            hold <= SC;
        end else if (hold != 0) begin
            hold <= hold - 1;
        end
        if (coinc && drive_pol) cores[m_addr] <= cores[m_addr] | ~inhibit_en;
        rd_prev <= coinc && !drive_pol;
    end

    // ---- cycle monitor ----
    int mon_chk = 0, mon_err = 0;
    int strobe_cnt = 0, rd_cyc = 0, wr_cyc = 0;
    logic [DW-1:0] cur_wb = '0;

    always @(negedge clk) begin
        noise <= DW'($urandom);
        if (rst_n) begin
            mon_chk <= mon_chk + 2;
            if (x_drive != y_drive) begin
                mon_err <= mon_err + 1;
                $display("FAIL R3 x_drive=%0b y_drive=%0b", x_drive, y_drive);
            end
            if (sense_en && inhibit_en != '0) begin
                mon_err <= mon_err + 1;
                $display("FAIL R7 inhibit=%0h during sense exp=0", inhibit_en);
            end
            if (coinc && drive_pol && inhibit_en != ~cur_wb) begin
                mon_err <= mon_err + 1;
                $display("FAIL R5 inhibit=%0h exp=%0h", inhibit_en, ~cur_wb);
            end
            if (!(coinc && drive_pol) && inhibit_en != '0) begin
                mon_err <= mon_err + 1;
                $display("FAIL R5 inhibit=%0h outside write exp=0", inhibit_en);
            end
            if (sense_en) strobe_cnt <= strobe_cnt + 1;
            if (coinc && !drive_pol) rd_cyc <= rd_cyc + 1;
            if (coinc && drive_pol) wr_cyc <= wr_cyc + 1;
        end
    end

    // ---- bench bookkeeping ----
    int nchecks = 0, errors = 0;
    bit finished = 1'b0;
    logic [DW-1:0] exp_mem [NW];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchecks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors + mon_err, nchecks + mon_chk);
            $finish;
        end
    endtask

    // Run one access; optionally inject a stray request while busy (R11).
    task automatic run_op(input bit wr, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input bit stray);
        int busy = 0;
        int rv_at = -1;
        int rv_n = 0;
        logic [DW-1:0] got = '0;
        logic [AW-1:0] sa = a ^ 6'h21;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        strobe_cnt = 0; rd_cyc = 0; wr_cyc = 0;
        cur_wb = wr ? d : exp_mem[a];
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && busy < 40) begin
            busy++;
            if (rd_valid) begin rv_at = busy; got = rd_data; rv_n++; end
            if (busy == RC + 1) begin
                chk({y_addr, x_addr} == a, "R3 addr split", {y_addr, x_addr}, a);
            end
            if (stray && busy == 3) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = sa; req_wdata = ~d;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        chk(busy == TOTAL, "R2 busy cycles", busy, TOTAL);
        chk(rd_cyc == RC && wr_cyc == WC, "R4 drive cycles", {rd_cyc[15:0], wr_cyc[15:0]},
            {16'(RC), 16'(WC)});
        chk(strobe_cnt == 1, "R6 strobe count", strobe_cnt, 1);
        if (!wr) begin
            chk(rv_at == RC + SC + 1 && rv_n == 1, "R8 rd_valid timing", rv_at, RC + SC + 1);
            chk(got == exp_mem[a], "R8 rd_data", got, exp_mem[a]);
            chk(cores[a] == exp_mem[a], "R8 write-back", cores[a], exp_mem[a]);
        end else begin
            chk(rv_n == 0, "R9 no rd_valid", rv_n, 0);
            exp_mem[a] = d;
            chk(cores[a] == d, "R9 stored", cores[a], d);
        end
        if (stray) begin
            chk(cores[sa] == exp_mem[sa], "R11 stray ignored", cores[sa], exp_mem[sa]);
            chk(req_ready && !x_drive, "R11 back to idle", {req_ready, x_drive}, 2'b10);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(req_ready && !x_drive && !y_drive && inhibit_en == '0 && !sense_en && !rd_valid,
            "R1 in reset", {req_ready, x_drive, sense_en, rd_valid}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !x_drive && inhibit_en == '0 && !rd_valid, "R1 after reset",
            {req_ready, x_drive, rd_valid}, 3'b100);
        // R9: fill every word with random data through writes
        for (int i = 0; i < NW; i++) run_op(1'b1, AW'(i), DW'($urandom), 1'b0);
        // Directed corner words
        run_op(1'b1, 6'h00, 8'h00, 1'b0);
        run_op(1'b1, 6'h3f, 8'hff, 1'b0);
        run_op(1'b1, 6'h15, 8'ha5, 1'b0);
        run_op(1'b0, 6'h00, 8'h00, 1'b0);
        run_op(1'b0, 6'h3f, 8'h00, 1'b0);
        run_op(1'b0, 6'h15, 8'h00, 1'b0);
        // R10: repeated reads keep the word
        for (int i = 0; i < 4; i++) run_op(1'b0, 6'h15, 8'h00, 1'b0);
        // R11: stray requests while busy
        run_op(1'b0, 6'h07, 8'h3c, 1'b1);
        run_op(1'b1, 6'h2a, 8'h5a, 1'b1);
        // Random mix
        for (int i = 0; i < 60; i++)
            run_op(1'($urandom), AW'($urandom), DW'($urandom), 1'($urandom));
        // R10: contents survive a controller reset
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            run_op(1'b0, AW'(i * 7), 8'h00, 1'b0);
            chk(cores[AW'(i * 7)] == exp_mem[AW'(i * 7)], "R10 after reset",
                cores[AW'(i * 7)], exp_mem[AW'(i * 7)]);
        end
        repeat (4) @(negedge clk);
        summary();
    end
endmodule